// File: doc/BRIEF.md
# Memory-Fill DMA Channel

A single DMA channel that writes a repeated 64-bit pattern over a contiguous memory region. Software programs it through a small word-addressed register file. The registers are a configuration word, a destination address, a byte count, the two 32-bit halves of the pattern and a command/status word. The channel then drives a beat-by-beat memory write port. Each beat is 64 bits wide, and beats are grouped into bursts marked by a last flag.

The channel is a three-state machine: idle, active and paused. Each command is honoured from one state only. Pause keeps the current address, the count of remaining beats and the position inside the burst, so restart continues the fill exactly where it stopped. A start is refused, and the channel stays idle, when the byte count is out of range or not a multiple of 8, or when the configuration is not in memory-fill mode.

Register word addresses: 0 configuration, 1 destination, 2 byte count, 3 pattern low, 4 pattern high, 5 command/status.

Top module: `fill_dma_chan`

## Requirements
- R1: After reset the status reads idle (0), no write request is raised, and the configuration word reads 0x0000_0440 (mode 0, source and destination burst limits 4).
- R2: The status field is bits [5:4] of word 5. It reads 0 for idle, 1 for active and 2 for paused. The value 3 never appears.
- R3: A start command (word 5 bit 0) is honoured only from idle and moves the channel to active. The fill begins at the destination address.
- R4: A pause command (bit 2) is honoured only while active and halts requests. A restart command (bit 3) is honoured only while paused and resumes at the saved address, beat count and burst position. Either command in any other state has no effect.
- R5: A stop command (bit 1) while active aborts the fill and returns the channel to idle. While idle, a stop has no effect.
- R6: The mode field is configuration bits [2:0], and memory-fill is code 2. A start in any other mode is refused. A configuration write with bit 31 set leaves the mode field unchanged and updates the source burst field [6:4], the destination burst field [10:8] and the protect bit [12].
- R7: Every beat carries the pattern {word 4, word 3}, with the high word in bits [63:32].
- R8: A start is refused, leaving the channel idle, when the byte count is below MIN_BYTES (default 16), above MAX_BYTES (default 2^20), or not a multiple of 8.
- R9: While the channel is active or paused, writes to words 1 to 4 are ignored. Their readback and the beats still in flight keep the earlier values.
- R10: Beat n goes to destination + 8n. A burst never extends past the last beat of the block. The channel returns to idle on the cycle after the final beat is acknowledged.
- R11: When several command bits are set in one write, only the highest-priority one is considered: stop, then pause, then restart, then start. It is applied if legal in the current state.
- R12: The burst length is the destination burst-limit field in beats, with 0 treated as 1. The last flag is high on the final beat of each burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| mem_req_o | output | 1 | Write beat request |
| mem_addr_o | output | 32 | Byte address of the beat |
| mem_data_o | output | 64 | Beat data |
| mem_last_o | output | 1 | Final beat of the current burst |
| mem_ack_i | input | 1 | Beat accepted |
| status_o | output | 2 | Channel state: 0 idle, 1 active, 2 paused |

## Verification
A corrupted state register shows at once on status_o and in mem_req_o, in the cycle after the command edge. A corrupted address or beat counter shows at the next acknowledged beat, as a wrong address, an early or late last flag, or a wrong total beat count. A pause or restart that loses progress appears as a gap or a repeat in the address sequence after the restart. A register that takes writes while busy shows in its readback and in the data of the following beats.

// File: rtl/fill_dma_pkg.sv
package fill_dma_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_ACTIVE = 2'd1, ST_PAUSED = 2'd2} chan_state_e;
  typedef enum logic [2:0] {CMD_NONE, CMD_START, CMD_STOP, CMD_PAUSE, CMD_RESTART} cmd_sel_e;

  localparam logic [2:0] REG_CFG    = 3'd0;
  localparam logic [2:0] REG_DST    = 3'd1;
  localparam logic [2:0] REG_SIZE   = 3'd2;
  localparam logic [2:0] REG_PAT_LO = 3'd3;
  localparam logic [2:0] REG_PAT_HI = 3'd4;
  localparam logic [2:0] REG_CMD    = 3'd5;

  localparam logic [2:0] MODE_FILL  = 3'd2;
  localparam int         CFG_KEEP_BIT = 31;

  localparam int CMD_START_BIT   = 0;
  localparam int CMD_STOP_BIT    = 1;
  localparam int CMD_PAUSE_BIT   = 2;
  localparam int CMD_RESTART_BIT = 3;

  typedef struct packed {
    logic       protect;
    logic [2:0] dst_burst;
    logic [2:0] src_burst;
    logic [2:0] mode;
  } cfg_t;
endpackage

// File: rtl/fill_regs.sv
module fill_regs
  import fill_dma_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [2:0]  addr_i,
  input  logic [31:0] wdata_i,
  input  logic        busy_i,
  input  logic [1:0]  state_i,
  output logic [31:0] rdata_o,
  output cfg_t        cfg_o,
  output logic [31:0] dst_o,
  output logic [31:0] size_o,
  output logic [63:0] pattern_o,
  output logic [3:0]  cmd_o
);
  cfg_t        cfg_q;
  logic [31:0] dst_q, size_q, lo_q, hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '{protect: 1'b0, dst_burst: 3'd4, src_burst: 3'd4, mode: 3'd0};
      dst_q <= '0; size_q <= '0; lo_q <= '0; hi_q <= '0;
    end else if (we_i) begin
      if (addr_i == REG_CFG) begin
        cfg_q.protect   <= wdata_i[12];
        cfg_q.dst_burst <= wdata_i[10:8];
        cfg_q.src_burst <= wdata_i[6:4];
        if (!wdata_i[CFG_KEEP_BIT]) cfg_q.mode <= wdata_i[2:0];
      end
      if (!busy_i) begin
        case (addr_i)
          REG_DST:    dst_q  <= wdata_i;
          REG_SIZE:   size_q <= wdata_i;
          REG_PAT_LO: lo_q   <= wdata_i;
          REG_PAT_HI: hi_q   <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  // self-clearing command pulses, decoded straight from the write strobe
  assign cmd_o = (we_i && addr_i == REG_CMD) ? wdata_i[3:0] : 4'd0;

  always_comb begin
    case (addr_i)
      REG_CFG:    rdata_o = {19'd0, cfg_q.protect, 1'b0, cfg_q.dst_burst, 1'b0,
                             cfg_q.src_burst, 1'b0, cfg_q.mode};
      REG_DST:    rdata_o = dst_q;
      REG_SIZE:   rdata_o = size_q;
      REG_PAT_LO: rdata_o = lo_q;
      REG_PAT_HI: rdata_o = hi_q;
      REG_CMD:    rdata_o = {26'd0, state_i, 4'd0};
      default:    rdata_o = '0;
    endcase
  end

  assign cfg_o     = cfg_q;
  assign dst_o     = dst_q;
  assign size_o    = size_q;
  assign pattern_o = {hi_q, lo_q};

  AST_BUSY_DST_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(dst_q)); // R9
  AST_BUSY_PAT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable({hi_q, lo_q})); // R9
  AST_MODE_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_CFG && wdata_i[CFG_KEEP_BIT]) |=> $stable(cfg_q.mode)); // R6
endmodule

// File: rtl/fill_ctrl.sv
module fill_ctrl
  import fill_dma_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned MIN_BYTES = 16,
  parameter int unsigned MAX_BYTES = 1 << 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        cmd_i,
  input  logic [2:0]        mode_i,
  input  logic [2:0]        burst_lim_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [31:0]       size_i,
  output logic              busy_o,
  output logic [1:0]        state_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_last_o,
  input  logic              mem_ack_i
);
  localparam int unsigned CNT_W = 29;

  chan_state_e       state_q;
  cmd_sel_e          sel;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  remain_q;
  logic [2:0]        burst_left_q, lim, cur_len;
  logic              size_ok, beat, final_beat;

  always_comb begin
    if      (cmd_i[CMD_STOP_BIT])    sel = CMD_STOP;
    else if (cmd_i[CMD_PAUSE_BIT])   sel = CMD_PAUSE;
    else if (cmd_i[CMD_RESTART_BIT]) sel = CMD_RESTART;
    else if (cmd_i[CMD_START_BIT])   sel = CMD_START;
    else                             sel = CMD_NONE;
  end

  assign size_ok = (size_i[2:0] == 3'd0) && (size_i >= 32'(MIN_BYTES)) &&
                   (size_i <= 32'(MAX_BYTES)) && (mode_i == MODE_FILL);

  assign lim     = (burst_lim_i == 3'd0) ? 3'd1 : burst_lim_i;
  assign cur_len = (burst_left_q != 3'd0) ? burst_left_q :
                   (remain_q < CNT_W'(lim)) ? remain_q[2:0] : lim;

  assign beat       = (state_q == ST_ACTIVE) && mem_ack_i;
  assign final_beat = beat && (remain_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      addr_q       <= '0;
      remain_q     <= '0;
      burst_left_q <= '0;
    end else begin
      if (beat) begin
        addr_q       <= addr_q + ADDR_W'(8);
        remain_q     <= remain_q - CNT_W'(1);
        burst_left_q <= cur_len - 3'd1;
      end
      case (state_q)
        ST_IDLE:
          if (sel == CMD_START && size_ok) begin
            state_q      <= ST_ACTIVE;
            addr_q       <= dst_i;
            remain_q     <= size_i[31:3];
            burst_left_q <= '0;
          end
        ST_ACTIVE:
          if (sel == CMD_STOP || final_beat) state_q <= ST_IDLE;
          else if (sel == CMD_PAUSE)          state_q <= ST_PAUSED;
        ST_PAUSED:
          if (sel == CMD_RESTART) state_q <= ST_ACTIVE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = state_q != ST_IDLE;
  assign state_o    = state_q;
  assign mem_req_o  = state_q == ST_ACTIVE;
  assign mem_addr_o = addr_q;
  assign mem_last_o = mem_req_o && (cur_len == 3'd1);

  AST_STATUS_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 2'd3); // R2
  AST_ACTIVE_NEEDS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACTIVE && $past(state_q) == ST_IDLE) |-> $past(sel == CMD_START)); // R3
  AST_PAUSE_HOLDS_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PAUSED) |=> $stable(addr_q) || state_q == ST_ACTIVE); // R4
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat |=> (addr_q == $past(addr_q) + ADDR_W'(8)) || state_q == ST_IDLE); // R10
  AST_BURST_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (cur_len != 3'd0) && (CNT_W'(cur_len) <= remain_q)); // R10
endmodule

// File: rtl/fill_dma_chan.sv
module fill_dma_chan
  import fill_dma_pkg::*;
#(
  parameter int unsigned MIN_BYTES = 16,
  parameter int unsigned MAX_BYTES = 1 << 20
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        mem_req_o,
  output logic [31:0] mem_addr_o,
  output logic [63:0] mem_data_o,
  output logic        mem_last_o,
  input  logic        mem_ack_i,
  output logic [1:0]  status_o
);
  cfg_t        cfg;
  logic [31:0] dst, size;
  logic [3:0]  cmd;
  logic        busy;

  fill_regs u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .busy_i(busy), .state_i(status_o), .rdata_o(reg_rdata_o),
    .cfg_o(cfg), .dst_o(dst), .size_o(size), .pattern_o(mem_data_o), .cmd_o(cmd)
  );

  fill_ctrl #(.ADDR_W(32), .MIN_BYTES(MIN_BYTES), .MAX_BYTES(MAX_BYTES)) u_ctrl (
    .clk_i, .rst_ni,
    .cmd_i(cmd), .mode_i(cfg.mode), .burst_lim_i(cfg.dst_burst),
    .dst_i(dst), .size_i(size),
    .busy_o(busy), .state_o(status_o),
    .mem_req_o, .mem_addr_o, .mem_last_o, .mem_ack_i
  );
endmodule

// File: tb/fill_dma_chan_bench.sv
module fill_dma_chan_bench;
  localparam int unsigned MAXB = 1 << 20;

  logic        clk = 0, rst_ni = 0;
  logic        we = 0, ack = 0;
  logic [2:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic        req, last;
  logic [31:0] maddr;
  logic [63:0] mdata;
  logic [1:0]  status;

  int checks = 0, errors = 0;
  bit done = 0;
  int beat_n = 0, lim = 4, nbeats = 0;
  logic [31:0] exp_dst = 0;
  logic [63:0] exp_pat = 0;

  always #2.5 clk = ~clk;

  fill_dma_chan #(.MIN_BYTES(16), .MAX_BYTES(MAXB)) u_fill_dma_chan (
    .clk_i(clk), .rst_ni, .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .mem_req_o(req), .mem_addr_o(maddr), .mem_data_o(mdata),
    .mem_last_o(last), .mem_ack_i(ack), .status_o(status)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  // beat monitor: a beat is accepted at the posedge following this negedge
  always @(negedge clk) if (rst_ni && req && ack) begin
    chk(maddr == exp_dst + 32'(8 * beat_n), "R10 beat address", maddr, exp_dst + 32'(8 * beat_n));
    chk(mdata == exp_pat, "R7 beat pattern", mdata, exp_pat);
    chk(last == (((beat_n % lim) == lim - 1) || (beat_n == nbeats - 1)), "R12 last flag",
        64'(last), 64'(((beat_n % lim) == lim - 1) || (beat_n == nbeats - 1)));
    beat_n++;
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1; we = 1; addr = a; wdata = d;
    @(posedge clk); #1; we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(posedge clk); #1; addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic setup(input logic [31:0] dst, input logic [31:0] sz, input logic [31:0] hi, input logic [31:0] lo);
    wr(3'd1, dst); wr(3'd2, sz); wr(3'd4, hi); wr(3'd3, lo);
    exp_dst = dst; exp_pat = {hi, lo}; nbeats = int'(sz >> 3); beat_n = 0;
  endtask

  task automatic st(input logic [1:0] e, input string tag);
    @(negedge clk);
    chk(status == e, tag, 64'(status), 64'(e));
  endtask

  // {byte count, start accepted}
  localparam logic [32:0] TBL [7] = '{
    {32'd8, 1'b0}, {32'd16, 1'b1}, {32'd20, 1'b0}, {32'(MAXB + 8), 1'b0},
    {32'(MAXB), 1'b1}, {32'd0, 1'b0}, {32'd12, 1'b0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=0x0 exp=0x1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk); #1; rst_ni = 1;
    // R1 reset state
    @(negedge clk);
    chk(status == 2'd0, "R1 status idle", 64'(status), 0);
    chk(req == 1'b0, "R1 no request", 64'(req), 0);
    rd(3'd0, d); chk(d == 32'h440, "R1 cfg reset", d, 32'h440);

    // R6 start refused outside fill mode
    setup(32'h1000, 32'd32, 32'hA5A5_0001, 32'h5A5A_0002);
    wr(3'd5, 32'h1); st(2'd0, "R6 start refused mode 0");
    wr(3'd0, 32'h0000_0442);
    wr(3'd0, 32'h8000_1220);
    rd(3'd0, d); chk(d == 32'h0000_1222, "R6 keep-mode write", d, 32'h0000_1222);
    wr(3'd0, 32'h0000_0442);

    // R8 size table walk, no acks
    ack = 0;
    foreach (TBL[i]) begin
      wr(3'd2, TBL[i][32:1]);
      wr(3'd5, 32'h1);
      st(TBL[i][0] ? 2'd1 : 2'd0, "R8 size check");
      wr(3'd5, 32'h2);
      st(2'd0, "R5 stop to idle");
    end

    // R3 R10 R7 R12 full fill, 10 beats, limit 4
    setup(32'h0000_2000, 32'd80, 32'hDEAD_0011, 32'hBEEF_0022);
    lim = 4; ack = 1;
    wr(3'd5, 32'h1);
    st(2'd1, "R3 start to active");
    repeat (12) @(posedge clk);
    st(2'd0, "R10 idle after final ack");
    chk(beat_n == 10, "R10 beat count", beat_n, 10);

    // R12 zero limit means 1
    wr(3'd0, 32'h0000_0042); lim = 1;
    setup(32'h0000_3000, 32'd24, 32'h1111_2222, 32'h3333_4444);
    wr(3'd5, 32'h1);
    repeat (5) @(posedge clk);
    chk(beat_n == 3, "R12 zero limit beats", beat_n, 3);
    wr(3'd0, 32'h0000_0442); lim = 4;

    // R4 R9 pause, ignored writes, restart
    setup(32'h0000_4000, 32'd80, 32'h0BAD_F00D, 32'hCAFE_1234);
    wr(3'd5, 32'h1);
    repeat (2) @(posedge clk);
    wr(3'd5, 32'h4);
    st(2'd2, "R4 pause to paused");
    d = 32'(beat_n);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req == 1'b0, "R4 no request while paused", 64'(req), 0);
    chk(32'(beat_n) == d, "R4 no beats while paused", beat_n, d);
    wr(3'd1, 32'h9999_0000); wr(3'd3, 32'h7777_7777); wr(3'd2, 32'd800);
    rd(3'd1, d); chk(d == 32'h0000_4000, "R9 dst write ignored", d, 32'h0000_4000);
    rd(3'd2, d); chk(d == 32'd80, "R9 size write ignored", d, 80);
    wr(3'd5, 32'h1); st(2'd2, "R3 start ignored while paused");
    wr(3'd5, 32'h3 << 1 & 32'h2); st(2'd2, "R5 stop ignored while paused");
    wr(3'd5, 32'h8); st(2'd1, "R4 restart to active");
    repeat (14) @(posedge clk);
    st(2'd0, "R4 resumed fill completes");
    chk(beat_n == 10, "R4 total beats after restart", beat_n, 10);

    // R5 stop mid-fill, then illegal commands in idle
    setup(32'h0000_5000, 32'd80, 32'h0, 32'h1);
    wr(3'd5, 32'h1);
    repeat (2) @(posedge clk);
    wr(3'd5, 32'h2);
    st(2'd0, "R5 stop aborts");
    chk(beat_n < 10, "R5 aborted early", beat_n, 10);
    @(negedge clk); chk(req == 1'b0, "R5 no request after stop", 64'(req), 0);
    wr(3'd5, 32'h8); st(2'd0, "R4 restart ignored in idle");
    wr(3'd5, 32'h4); st(2'd0, "R4 pause ignored in idle");
    wr(3'd5, 32'h2); st(2'd0, "R5 stop no-op in idle");

    // R11 priority, no acks
    ack = 0;
    setup(32'h0000_6000, 32'd64, 32'h2, 32'h3);
    wr(3'd5, 32'h1);  st(2'd1, "R11 start");
    wr(3'd5, 32'hD);  st(2'd2, "R11 pause over restart/start");
    wr(3'd5, 32'h6);  st(2'd2, "R11 stop over pause while paused");
    wr(3'd5, 32'h9);  st(2'd1, "R11 restart over start");
    wr(3'd5, 32'hF);  st(2'd0, "R11 stop over all");
    wr(3'd5, 32'h3);  st(2'd0, "R11 stop wins over start in idle");
    rd(3'd5, d); chk(d[5:4] == 2'd0, "R2 status field idle", 64'(d[5:4]), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule